// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer

This block is a memory-mapped peripheral with six independent 32-bit timer channels behind a simple register bus. The bus has an address, a write strobe, write data, and a combinational read data path. Each channel counts down from a current value. It divides a shared tick input by a power of two that is set per channel. When the count reaches zero it raises a pending flag. Depending on its mode bits, the channel then either reloads from its interval register and keeps running, or stops.

Each pending flag is gated by its own enable bit. All the gated flags are ORed into one interrupt line. Software acknowledges a flag by writing a one to its bit in the status register. The clock-source field of each channel is stored and can be read back, but it has no effect. The only timing input is a single tick-enable signal shared by all channels.

Top module: `ivtimer_bank`

## Requirements
- R1: After reset, every readable register reads 0 and `irq_o` is low.
- R2: Register map, byte addresses with bits 1:0 = 0:
  - 0x00 is the interrupt-enable register; bit n enables channel n.
  - 0x04 is the pending register; bit n is channel n's flag.
  - Channel n uses 0x10+0x10·n for control, 0x14+0x10·n for the interval, and 0x18+0x10·n for the current value.
  - Any other address reads 0 and ignores writes. This includes addresses whose bits 1:0 are not zero.
  - Writes take effect on the next clock edge.
- R3: Control register fields:
  - bit 0 start
  - bit 1 autoreload
  - bits 3:2 clock source (stored only)
  - bits 6:4 prescaler p
  - bit 7 single-shot
  - Bits 31:8 read as 0.
- R4: A started channel's current value drops by one on each divided tick. With p = 0, every cycle with `tick_en` high is a divided tick. With p > 0, every 2^p-th tick of the run is a divided tick. The value does not change when `tick_en` is low.
- R5: Expiry is the decrement from 1 to 0. The expiry sets the channel's pending bit on the same clock edge.
- R6: If autoreload = 1 and single-shot = 0 at expiry, the current value is loaded from the interval register and the channel keeps running.
- R7: In every other case, the channel stops at expiry. Hardware clears start, and the current value stays at 0.
- R8: When software clears start, the current value freezes.
- R9: A software write to the current value sets the count directly. It takes priority over a decrement in the same cycle.
- R10: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged. An expiry in the same cycle takes priority over the clear.
- R11: `irq_o` is the OR over all channels of (pending AND enable).
- R12: The channels count, expire and flag independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Shared timer tick enable |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench steps the tick one edge at a time. This lets it show that the flag appears on exactly the 1-to-0 edge. A design that fired on reaching 1, or one edge late, fails the pending check.

It covers the modes that differ at expiry:
- Autoreload with single-shot clear must reload and keep running. A wrong design stops here or leaves the count at 0.
- Autoreload with single-shot set must stop. A wrong design reloads here.
- A prescaler of 2 must hold the count for three ticks. A wrong design decrements early.

The bench also checks the register rules:
- A zero write to the status register must leave the flags alone. A design that cleared on any write would lose them.
- A misaligned write must not alias onto a real register.
- A pending flag whose enable is off must not assert the interrupt.
- Two channels that expire on different ticks must not disturb each other's flags.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int CTRL_W = 8;
    localparam int PRE_W  = 3;

    // Control register layout, bit 0 at the bottom.
    typedef struct packed {
        logic             single;
        logic [PRE_W-1:0] pre;
        logic [1:0]       src;
        logic             autorel;
        logic             start;
    } ivt_ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_INTV = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_NONE = 2'd3
    } ivt_sel_e;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] shift_i,
    output logic             div_tick_o
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask       = ({{(CNT_W-1){1'b0}}, 1'b1} << shift_i) - {{(CNT_W-1){1'b0}}, 1'b1};
        div_tick_o = run_i && tick_i && ((cnt_q & mask) == mask);
        cnt_d      = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_intv_i,
    input  logic              wr_cur_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ivt_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] intv_o,
    output logic [DATA_W-1:0] cur_o,
    output logic              expire_o
);
    typedef struct packed {
        ivt_ctrl_t         ctrl;
        logic [DATA_W-1:0] intv;
        logic [DATA_W-1:0] cur;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     div_tick;
    logic     reload_mode;

    ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.ctrl.start),
        .tick_i     (tick_i),
        .shift_i    (st_q.ctrl.pre),
        .div_tick_o (div_tick)
    );

    always_comb begin
        reload_mode = st_q.ctrl.autorel && !st_q.ctrl.single;
        expire_o    = div_tick && (st_q.cur == DATA_W'(1));
        st_d        = st_q;
        if (div_tick) begin
            if (expire_o) begin
                if (reload_mode) begin
                    st_d.cur = st_q.intv;
                end else begin
                    st_d.cur        = '0;
                    st_d.ctrl.start = 1'b0;
                end
            end else begin
                st_d.cur = st_q.cur - DATA_W'(1);
            end
        end
        // Software writes win over hardware updates.
        if (wr_ctrl_i) st_d.ctrl = ivt_ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (wr_intv_i) st_d.intv = wdata_i;
        if (wr_cur_i)  st_d.cur  = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign intv_o = st_q.intv;
    assign cur_o  = st_q.cur;

    assert_expiry_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !reload_mode && !wr_ctrl_i) |=> !st_q.ctrl.start);

    assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_mode && !wr_cur_i) |=> (st_q.cur == $past(st_q.intv)));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.start && !wr_cur_i) |=> $stable(st_q.cur));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.start && !expire_o && !wr_cur_i) |=>
        ((st_q.cur == $past(st_q.cur)) || (st_q.cur == $past(st_q.cur) - DATA_W'(1))));
endmodule

// File: rtl/ivt_irq_ctrl.sv
module ivt_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_clr_i,
    input  logic [NUM_CH-1:0] wdata_i,
    input  logic [NUM_CH-1:0] expire_i,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i)  st_d.en   = wdata_i;
        if (wr_clr_i) st_d.pend = st_q.pend & ~wdata_i;
        st_d.pend = st_d.pend | expire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & st_q.en);

    assert_pending_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i != '0) |=> ((st_q.pend & $past(expire_i)) == $past(expire_i)));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_i |=> ((st_q.pend & $past(wdata_i & ~expire_i)) == '0));
endmodule

// File: rtl/ivtimer_bank.sv
module ivtimer_bank
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0]  blk;
    ivt_sel_e          sel;
    logic              aligned;
    logic              wr_en, wr_clr;

    ivt_ctrl_t         ch_ctrl [NUM_CH];
    logic [DATA_W-1:0] ch_intv [NUM_CH];
    logic [DATA_W-1:0] ch_cur  [NUM_CH];
    logic [NUM_CH-1:0] ch_exp;
    logic [NUM_CH-1:0] irq_en, irq_pend;

    assign blk     = bus_addr[ADDR_W-1:4];
    assign sel     = ivt_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_we && aligned && (blk == '0) && (sel == SEL_CTRL);
    assign wr_clr  = bus_we && aligned && (blk == '0) && (sel == SEL_INTV);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_we && aligned && (blk == BLK_W'(c + 1));

        ivt_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_en),
            .wr_ctrl_i (hit && (sel == SEL_CTRL)),
            .wr_intv_i (hit && (sel == SEL_INTV)),
            .wr_cur_i  (hit && (sel == SEL_CUR)),
            .wdata_i   (bus_wdata),
            .ctrl_o    (ch_ctrl[c]),
            .intv_o    (ch_intv[c]),
            .cur_o     (ch_cur[c]),
            .expire_o  (ch_exp[c])
        );
    end

    ivt_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_clr_i (wr_clr),
        .wdata_i  (bus_wdata[NUM_CH-1:0]),
        .expire_i (ch_exp),
        .en_o     (irq_en),
        .pend_o   (irq_pend),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (blk == '0) begin
                if (sel == SEL_CTRL)      bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, irq_en};
                else if (sel == SEL_INTV) bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, irq_pend};
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (blk == BLK_W'(c + 1)) begin
                    case (sel)
                        SEL_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ch_ctrl[c]};
                        SEL_INTV: bus_rdata = ch_intv[c];
                        SEL_CUR:  bus_rdata = ch_cur[c];
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: tb/ivtimer_bank_tb.sv
module ivtimer_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ivtimer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] ctl(input int n);  return 8'(8'h10 + 8'h10 * n); endfunction
    function automatic logic [7:0] itv(input int n);  return 8'(8'h14 + 8'h10 * n); endfunction
    function automatic logic [7:0] cva(input int n);  return 8'(8'h18 + 8'h10 * n); endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rdchk("R1 ien", 8'h00, 0);
        rdchk("R1 pend", 8'h04, 0);
        rdchk("R1 ctrl0", ctl(0), 0);
        rdchk("R1 intv0", itv(0), 0);
        rdchk("R1 cur5", cva(5), 0);
        chk("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_oneshot;
        wr(8'h00, 32'h1);
        wr(itv(0), 7);
        wr(cva(0), 3);
        wr(ctl(0), 32'h1);
        idle(4);
        rdchk("R4 no tick no change", cva(0), 3);
        ticks(2);
        rdchk("R4 p0 count", cva(0), 1);
        rdchk("R5 not yet pending", 8'h04, 0);
        ticks(1);
        rdchk("R5 expiry value", cva(0), 0);
        rdchk("R5 pending set", 8'h04, 32'h1);
        rdchk("R7 start cleared", ctl(0), 0);
        chk("R11 irq on", 32'(irq_o), 1);
        ticks(2);
        rdchk("R7 stays zero", cva(0), 0);
        wr(8'h04, 32'h1);
        rdchk("R10 cleared", 8'h04, 0);
        chk("R11 irq off", 32'(irq_o), 0);
    endtask

    task automatic t_reload;
        wr(itv(1), 2);
        wr(cva(1), 2);
        wr(ctl(1), 32'h3);
        ticks(2);
        rdchk("R6 reloaded", cva(1), 2);
        rdchk("R6 pending", 8'h04, 32'h2);
        rdchk("R6 still running", ctl(1), 32'h3);
        wr(8'h04, 32'h2);
        ticks(2);
        rdchk("R6 fires again", 8'h04, 32'h2);
        wr(8'h04, 32'h2);
        ticks(1);
        rdchk("R8 before stop", cva(1), 1);
        wr(ctl(1), 32'h0);
        ticks(3);
        rdchk("R8 frozen", cva(1), 1);
    endtask

    task automatic t_single;
        wr(itv(2), 5);
        wr(cva(2), 1);
        wr(ctl(2), 32'h83);
        ticks(1);
        rdchk("R7 single no reload", cva(2), 0);
        rdchk("R7 single stops", ctl(2), 32'h82);
        rdchk("R5 ch2 pending", 8'h04, 32'h4);
        chk("R11 masked pending", 32'(irq_o), 0);
        wr(8'h04, 32'h0);
        rdchk("R10 zero write keeps", 8'h04, 32'h4);
        wr(8'h04, 32'h4);
        rdchk("R10 ch2 cleared", 8'h04, 0);
    endtask

    task automatic t_prescale;
        wr(cva(3), 2);
        wr(ctl(3), 32'h21);
        ticks(3);
        rdchk("R4 prescale hold", cva(3), 2);
        ticks(1);
        rdchk("R4 prescale step", cva(3), 1);
        ticks(3);
        rdchk("R4 prescale hold2", cva(3), 1);
        ticks(1);
        rdchk("R5 prescale expiry", 8'h04, 32'h8);
        wr(8'h04, 32'h8);
    endtask

    task automatic t_fields_and_write;
        wr(ctl(4), 32'hFFFF_FF8C);
        rdchk("R3 field readback", ctl(4), 32'h8C);
        wr(cva(4), 32'h1234);
        ticks(2);
        rdchk("R9 direct write held", cva(4), 32'h1234);
        wr(cva(4), 5);
        wr(ctl(4), 32'h1);
        ticks(1);
        rdchk("R9 counting", cva(4), 4);
        wr(cva(4), 2);
        rdchk("R9 rewritten", cva(4), 2);
        ticks(1);
        rdchk("R9 from new value", cva(4), 1);
        ticks(1);
        rdchk("R9 expiry", 8'h04, 32'h10);
        wr(8'h04, 32'h10);
    endtask

    task automatic t_unmapped;
        wr(itv(0), 7);
        rdchk("R2 off 08", 8'h08, 0);
        rdchk("R2 off 0C", 8'h0C, 0);
        rdchk("R2 off 1C", 8'h1C, 0);
        rdchk("R2 off 70", 8'h70, 0);
        rdchk("R2 misaligned", 8'h15, 0);
        wr(8'h15, 32'h99);
        rdchk("R2 misaligned write ignored", itv(0), 7);
    endtask

    task automatic t_multi;
        wr(8'h00, 32'h21);
        wr(itv(5), 3);
        wr(cva(5), 1);
        wr(cva(0), 2);
        wr(ctl(5), 32'h3);
        wr(ctl(0), 32'h1);
        ticks(1);
        rdchk("R12 ch5 fired alone", 8'h04, 32'h20);
        rdchk("R12 ch0 counting", cva(0), 1);
        ticks(1);
        rdchk("R12 both pending", 8'h04, 32'h21);
        rdchk("R12 ch5 after reload", cva(5), 2);
        wr(8'h04, 32'h20);
        rdchk("R12 ch0 kept", 8'h04, 32'h01);
        chk("R11 irq one left", 32'(irq_o), 1);
        wr(8'h04, 32'h01);
        chk("R11 irq none left", 32'(irq_o), 0);
        wr(ctl(5), 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_oneshot;
        t_reload;
        t_single;
        t_prescale;
        t_fields_and_write;
        t_unmapped;
        t_multi;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule